// File: doc/BRIEF.md
# Cluster-Mode Address Home Router

On a mesh-based multicore die, a private-cache miss has to be steered to a home agent, which is the last-level-cache slice that owns the line. The same request also needs to know which memory controller that home agent will use if the line misses in the last-level cache or a dirty line is written back. This block takes the physical address of the miss and the identifier of the requesting core. From these it returns a home-agent index and a memory-controller index, one cycle after the request is accepted.

A small configuration register selects one of five cluster modes:
- **Global interleave.** Every home agent and every populated controller takes part.
- **Two-way split.** Memory is divided into two equal contiguous regions, and each region is bound to one half of the die.
- **Four-way split.** The same scheme with four regions, each bound to one quarter of the die.
- **Hybrid half.** The home agent is picked by the global hash, and the memory access stays inside that agent's half of the die.
- **Hybrid quarter.** The home agent is picked by the global hash, and the memory access goes to the controller nearest that agent.

The register also holds the log2 of the installed memory size, which places the region boundaries for the split modes. The defaults are 16 home agents, 4 controllers, 40-bit addresses and 64-byte lines.

Top module: `hr_router`

## Requirements
- R1: The line-offset bits `req_addr[5:0]` have no effect on `rsp_ha` or `rsp_mc` in any mode.
- R2: Mode code 0 (global interleave) works as follows. The line address `L = req_addr[39:6]` is zero-padded and split into 4-bit chunks, with chunk k being `L[4k+3:4k]`. `rsp_ha` is the XOR of all chunks; call this value h. `rsp_mc` is the XOR of the 2-bit chunks of L; call this value m.
- R3: Mode code 1 (two-way split) uses region r = `req_addr[S-1]`, where S is the stored size field. It gives `rsp_ha = 8r + (h mod 8)` and `rsp_mc = 2r + (m mod 2)`, whatever core made the request.
- R4: Mode code 2 (four-way split) uses region r = `req_addr[S-1:S-2]`. It gives `rsp_ha = 4r + (h mod 4)` and `rsp_mc = r`.
- R5: Mode code 4 (hybrid quarter) gives `rsp_ha = h`. `rsp_mc` is the controller nearest that agent, `h div 4`, because controller q sits in the quarter that holds agents 4q to 4q+3.
- R6: Mode code 3 (hybrid half) gives `rsp_ha = h` and `rsp_mc = 2*(h div 8) + (m mod 2)`.
- R7: `req_core` never affects `rsp_ha` or `rsp_mc`. It is returned unchanged on `rsp_core` alongside the result.
- R8: A configuration write with code 0 to 4 is taken at the clock edge when both `req_valid` and `rsp_valid` are low. It applies to every request accepted after that edge, and `cfg_err` stays low.
- R9: A configuration write is ignored in two cases: it arrives while `req_valid` or `rsp_valid` is high, or it carries code 5, 6 or 7. In either case the stored mode and size keep their values, and `cfg_err` is high for exactly the one cycle after the write.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at an edge shows up on the `rsp_*` outputs, with `rsp_valid` high, right after that edge.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_ha`, `rsp_mc` and `rsp_core` hold their values.
- R12: After reset, `rsp_valid` and `cfg_err` are low, the mode is global interleave, and the size field is 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Cluster-mode code to write |
| cfg_size | input | 6 | log2 of installed memory bytes, to write |
| cfg_err | output | 1 | One-cycle pulse: the write was refused |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 40 | Physical address of the miss |
| req_core | input | 4 | Requesting core identifier |
| rsp_valid | output | 1 | Routing result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_ha | output | 4 | Selected home-agent index |
| rsp_mc | output | 2 | Selected memory-controller index |
| rsp_core | output | 4 | Core identifier of the routed request |

## Verification
The cluster-locality properties take one thing for granted: the mode seen while a response is held is the mode that routed it. That holds only because a configuration write is refused whenever a request is pending. The properties also assume a size field of at least 2, so that the region bits exist. The stimulus only ever writes sizes between 20 and 40. It issues configuration writes in three situations: when the pipeline is idle, alongside a live request, or under a held response, and in the last two it expects the write to be refused. The sweeps cover every mode at two sizes, with addresses whose high bits cross all region boundaries. Offset bits and core identifiers are varied separately against the same line.

// File: rtl/hr_pkg.sv
package hr_pkg;
   typedef enum logic [2:0] {
      CM_ALL    = 3'd0,
      CM_SPLIT2 = 3'd1,
      CM_SPLIT4 = 3'd2,
      CM_HEMI   = 3'd3,
      CM_QUAD   = 3'd4
   } cm_mode_e;

   function automatic logic mode_legal(input logic [2:0] code);
      return code <= 3'd4;
   endfunction
endpackage

// File: rtl/hr_fold.sv
module hr_fold #(
   parameter int IN_W  = 34,
   parameter int OUT_W = 4
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int NCHUNK = (IN_W + OUT_W - 1) / OUT_W;
   localparam int PAD_W  = NCHUNK * OUT_W;

   logic [PAD_W-1:0] ext;
   logic [OUT_W-1:0] acc [NCHUNK+1];

   assign ext    = PAD_W'(din);
   assign acc[0] = '0;

   for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
      assign acc[g+1] = acc[g] ^ ext[g*OUT_W +: OUT_W];
   end

   assign dout = acc[NCHUNK];
endmodule

// File: rtl/hr_ha_table.sv
module hr_ha_table #(
   parameter int NUM_HA = 16,
   parameter int NUM_MC = 4
) (
   input  logic [$clog2(NUM_HA)-1:0] ha,
   output logic [$clog2(NUM_MC)-1:0] near_mc,
   output logic                      hemi
);
   localparam int MC_W = $clog2(NUM_MC);
   localparam int HPQ  = NUM_HA / 4;
   localparam int MPQ  = NUM_MC / 4;

   logic [MC_W-1:0] near_tbl [NUM_HA];
   logic            hemi_tbl [NUM_HA];

   for (genvar g = 0; g < NUM_HA; g++) begin : g_agent
      assign near_tbl[g] = MC_W'((g / HPQ) * MPQ + ((g % HPQ) * MPQ) / HPQ);
      assign hemi_tbl[g] = (g >= NUM_HA / 2);
   end

   assign near_mc = near_tbl[ha];
   assign hemi    = hemi_tbl[ha];
endmodule

// File: rtl/hr_pick.sv
module hr_pick import hr_pkg::*; #(
   parameter int ADDR_W   = 40,
   parameter int LINE_OFF = 6,
   parameter int NUM_HA   = 16,
   parameter int NUM_MC   = 4,
   parameter int SZ_W     = 6
) (
   input  cm_mode_e                  mode,
   input  logic [SZ_W-1:0]           size,
   input  logic [ADDR_W-1:0]         addr,
   output logic [$clog2(NUM_HA)-1:0] ha,
   output logic [$clog2(NUM_MC)-1:0] mc
);
   localparam int HA_W   = $clog2(NUM_HA);
   localparam int MC_W   = $clog2(NUM_MC);
   localparam int LINE_W = ADDR_W - LINE_OFF;
   localparam int MPH    = NUM_MC / 2;
   localparam int MPQ    = NUM_MC / 4;

   logic [LINE_W-1:0] line;
   logic [HA_W-1:0]   h;
   logic [MC_W-1:0]   m;
   logic [SZ_W-1:0]   sh1, sh2;
   logic              r2;
   logic [1:0]        r4;
   logic [MC_W-1:0]   near_mc;
   logic              hemi;

   assign line = addr[ADDR_W-1:LINE_OFF];

   hr_fold #(.IN_W(LINE_W), .OUT_W(HA_W)) u_fold_ha (.din(line), .dout(h));
   hr_fold #(.IN_W(LINE_W), .OUT_W(MC_W)) u_fold_mc (.din(line), .dout(m));

   assign sh1 = size - SZ_W'(1);
   assign sh2 = size - SZ_W'(2);
   assign r2  = 1'(addr >> sh1);
   assign r4  = 2'(addr >> sh2);

   hr_ha_table #(.NUM_HA(NUM_HA), .NUM_MC(NUM_MC)) u_tbl (
      .ha(h), .near_mc(near_mc), .hemi(hemi)
   );

   always_comb begin
      ha = h;
      mc = m;
      unique case (mode)
         CM_SPLIT2: begin
            ha = {r2, h[HA_W-2:0]};
            mc = MC_W'(int'(r2) * MPH + int'(m) % MPH);
         end
         CM_SPLIT4: begin
            ha = {r4, h[HA_W-3:0]};
            mc = MC_W'(int'(r4) * MPQ + int'(m) % MPQ);
         end
         CM_HEMI: begin
            mc = MC_W'(int'(hemi) * MPH + int'(m) % MPH);
         end
         CM_QUAD: begin
            mc = near_mc;
         end
         default: begin
            ha = h;
            mc = m;
         end
      endcase
   end
endmodule

// File: rtl/hr_cfg.sv
module hr_cfg import hr_pkg::*; #(
   parameter int SZ_W   = 6,
   parameter int SZ_RST = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [2:0]      wr_mode,
   input  logic [SZ_W-1:0] wr_size,
   input  logic            busy,
   output cm_mode_e        mode,
   output logic [SZ_W-1:0] size,
   output logic            err
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= CM_ALL;
         size <= SZ_W'(SZ_RST);
         err  <= 1'b0;
      end else begin
         err <= 1'b0;
         if (wr_en) begin
            if (busy || !mode_legal(wr_mode)) begin
               err <= 1'b1;
            end else begin
               mode <= cm_mode_e'(wr_mode);
               size <= wr_size;
            end
         end
      end
   end
endmodule

// File: rtl/hr_router.sv
module hr_router import hr_pkg::*; #(
   parameter int ADDR_W   = 40,
   parameter int LINE_OFF = 6,
   parameter int NUM_HA   = 16,
   parameter int NUM_MC   = 4,
   parameter int CORE_W   = 4,
   parameter int HA_W     = $clog2(NUM_HA),
   parameter int MC_W     = $clog2(NUM_MC),
   parameter int SZ_W     = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_mode,
   input  logic [SZ_W-1:0]   cfg_size,
   output logic              cfg_err,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CORE_W-1:0] req_core,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [HA_W-1:0]   rsp_ha,
   output logic [MC_W-1:0]   rsp_mc,
   output logic [CORE_W-1:0] rsp_core
);
   if ((NUM_HA & (NUM_HA - 1)) != 0 || NUM_HA < 4) begin : g_bad_ha
      $error("NUM_HA must be a power of two of at least 4");
   end
   if ((NUM_MC & (NUM_MC - 1)) != 0 || NUM_MC < 4 || NUM_MC > NUM_HA) begin : g_bad_mc
      $error("NUM_MC must be a power of two between 4 and NUM_HA");
   end
   if (LINE_OFF < 1 || LINE_OFF + HA_W > ADDR_W) begin : g_bad_line
      $error("LINE_OFF leaves too few line-address bits");
   end

   cm_mode_e        cur_mode;
   logic [SZ_W-1:0] cur_size;
   logic [HA_W-1:0] nxt_ha;
   logic [MC_W-1:0] nxt_mc;
   logic            busy;
   logic            accept;

   assign busy      = req_valid | rsp_valid;
   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;

   hr_cfg #(.SZ_W(SZ_W), .SZ_RST(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_mode(cfg_mode),
      .wr_size(cfg_size), .busy(busy), .mode(cur_mode), .size(cur_size),
      .err(cfg_err)
   );

   hr_pick #(
      .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .NUM_HA(NUM_HA),
      .NUM_MC(NUM_MC), .SZ_W(SZ_W)
   ) u_pick (
      .mode(cur_mode), .size(cur_size), .addr(req_addr),
      .ha(nxt_ha), .mc(nxt_mc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ha    <= '0;
         rsp_mc    <= '0;
         rsp_core  <= '0;
      end else begin
         if (req_ready) rsp_valid <= req_valid;
         if (accept) begin
            rsp_ha   <= nxt_ha;
            rsp_mc   <= nxt_mc;
            rsp_core <= req_core;
         end
      end
   end
endmodule

// File: rtl/hr_router_chk.sv
module hr_router_chk import hr_pkg::*; #(
   parameter int NUM_HA = 16,
   parameter int NUM_MC = 4,
   parameter int HA_W   = 4,
   parameter int MC_W   = 2,
   parameter int SZ_W   = 6,
   parameter int CORE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic              cfg_err,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [HA_W-1:0]   rsp_ha,
   input logic [MC_W-1:0]   rsp_mc,
   input logic [CORE_W-1:0] rsp_core,
   input cm_mode_e          mode,
   input logic [SZ_W-1:0]   size
);
   localparam int HPQ = NUM_HA / 4;
   localparam int HPH = NUM_HA / 2;
   localparam int MPQ = NUM_MC / 4;
   localparam int MPH = NUM_MC / 2;

   // R10
   accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid);

   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ha)
         && $stable(rsp_mc) && $stable(rsp_core));

   // R4
   split4_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && mode == CM_SPLIT4 |-> (int'(rsp_mc) / MPQ) == (int'(rsp_ha) / HPQ));

   // R3
   split2_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && mode == CM_SPLIT2 |-> (int'(rsp_mc) / MPH) == (int'(rsp_ha) / HPH));

   // R5
   quad_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && mode == CM_QUAD |-> (int'(rsp_mc) / MPQ) == (int'(rsp_ha) / HPQ));

   // R6
   hemi_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && mode == CM_HEMI |-> (int'(rsp_mc) / MPH) == (int'(rsp_ha) / HPH));

   // R9
   cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && (req_valid || rsp_valid) |=> cfg_err && $stable(mode) && $stable(size));

   // R9
   cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> !cfg_err);
endmodule

bind hr_router hr_router_chk #(
   .NUM_HA(NUM_HA), .NUM_MC(NUM_MC), .HA_W(HA_W), .MC_W(MC_W),
   .SZ_W(SZ_W), .CORE_W(CORE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_err(cfg_err),
   .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready), .rsp_ha(rsp_ha), .rsp_mc(rsp_mc),
   .rsp_core(rsp_core), .mode(cur_mode), .size(cur_size)
);

// File: tb/tb_hr_router.sv
`timescale 1ns/1ps
module tb_hr_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_mode = '0;
   logic [5:0]  cfg_size = '0;
   logic        cfg_err;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [39:0] req_addr = '0;
   logic [3:0]  req_core = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [3:0]  rsp_ha;
   logic [1:0]  rsp_mc;
   logic [3:0]  rsp_core;

   int n_chk = 0;
   int n_err = 0;
   int cur_md = 0;
   int cur_sz = 40;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hr_router dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
      .cfg_size(cfg_size), .cfg_err(cfg_err), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .req_core(req_core),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ha(rsp_ha),
      .rsp_mc(rsp_mc), .rsp_core(rsp_core)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int fold(input longint line, input int w);
      int r = 0;
      for (int i = 0; i < 34; i++)
         if (((line >> i) & 1) != 0) r = r ^ (1 << (i % w));
      return r;
   endfunction

   function automatic int exp_ha(input int md, input int sz, input logic [39:0] a);
      longint la = longint'(a);
      int h  = fold(la >> 6, 4);
      int r2 = int'((la >> (sz - 1)) & 1);
      int r4 = int'((la >> (sz - 2)) & 3);
      case (md)
         1: return 8 * r2 + h % 8;
         2: return 4 * r4 + h % 4;
         default: return h;
      endcase
   endfunction

   function automatic int exp_mc(input int md, input int sz, input logic [39:0] a);
      longint la = longint'(a);
      int h  = fold(la >> 6, 4);
      int m  = fold(la >> 6, 2);
      int r2 = int'((la >> (sz - 1)) & 1);
      int r4 = int'((la >> (sz - 2)) & 3);
      case (md)
         1: return 2 * r2 + m % 2;
         2: return r4;
         3: return 2 * (h / 8) + m % 2;
         4: return h / 4;
         default: return m;
      endcase
   endfunction

   task automatic send_chk(input logic [39:0] a, input logic [3:0] c, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_core = c;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " valid (R10)"}, int'(rsp_valid), 1);
      chk({tag, " ha"}, int'(rsp_ha), exp_ha(cur_md, cur_sz, a));
      chk({tag, " mc"}, int'(rsp_mc), exp_mc(cur_md, cur_sz, a));
      chk({tag, " core (R7)"}, int'(rsp_core), int'(c));
   endtask

   task automatic set_cfg(input int md, input int sz);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_mode = 3'(md); cfg_size = 6'(sz);
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R8 idle write err", int'(cfg_err), 0);
      cur_md = md; cur_sz = sz;
   endtask

   function automatic logic [39:0] mix(input int i);
      longint v = longint'(i) * 64'h0000_0001_2F5A_3C71 + longint'(i) * 37;
      return v[39:0];
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 rsp_valid", int'(rsp_valid), 0);
      chk("R12 cfg_err", int'(cfg_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 ready idle", int'(req_ready), 1);
      // R12 default mode is global interleave
      send_chk(40'h12_3456_7890, 4'd3, "R12 default R2");

      // R2 R3 R4 R5 R6 sweeps over modes and sizes
      for (int md = 0; md < 5; md++) begin
         for (int s = 0; s < 2; s++) begin
            int sz = (s == 0) ? 40 : 24;
            set_cfg(md, sz);
            for (int i = 0; i < 200; i++)
               send_chk(mix(i + md * 1000 + s * 500), 4'(i), $sformatf("R%0d sweep", md == 0 ? 2 : md == 1 ? 3 : md == 2 ? 4 : md == 3 ? 6 : 5));
            for (int rg = 0; rg < 4; rg++)
               for (int j = 0; j < 16; j++)
                  send_chk((40'(rg) << (sz - 2)) | (40'(j) << 6), 4'd0, "R3 R4 region");
         end
      end

      // R1 offset bits ignored
      set_cfg(2, 30);
      for (int o = 0; o < 64; o++) begin
         logic [39:0] base = 40'h2A_C0DE_1000;
         send_chk(base | 40'(o), 4'd5, "R1 offset");
         chk("R1 same ha as offset 0", int'(rsp_ha), exp_ha(2, 30, base));
      end

      // R7 core id ignored
      set_cfg(4, 40);
      for (int c = 0; c < 16; c++) begin
         send_chk(40'h77_1234_5640, 4'(c), "R7 core");
         chk("R7 ha independent of core", int'(rsp_ha), exp_ha(4, 40, 40'h77_1234_5640));
      end

      // R9 write with request pending is refused
      @(negedge clk);
      req_valid = 1'b1; req_addr = 40'h05_5555_5540; req_core = 4'd9;
      cfg_wr = 1'b1; cfg_mode = 3'd0; cfg_size = 6'd40;
      @(negedge clk);
      req_valid = 1'b0; cfg_wr = 1'b0;
      chk("R9 busy err", int'(cfg_err), 1);
      chk("R9 old-mode mc", int'(rsp_mc), exp_mc(4, 40, 40'h05_5555_5540));
      @(negedge clk);
      chk("R9 err one cycle", int'(cfg_err), 0);
      send_chk(40'h3F_0F0F_0F00, 4'd1, "R9 mode kept");

      // R9 illegal code refused
      @(negedge clk);
      cfg_wr = 1'b1; cfg_mode = 3'd6; cfg_size = 6'd20;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R9 illegal err", int'(cfg_err), 1);
      send_chk(40'h01_89AB_CDC0, 4'd2, "R9 illegal kept");

      // R10 R11 backpressure, plus R9 with a held response
      set_cfg(1, 36);
      @(negedge clk);
      rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 40'hA1_0000_1240; req_core = 4'd4;
      @(negedge clk);
      chk("R10 valid", int'(rsp_valid), 1);
      chk("R10 ready low", int'(req_ready), 0);
      req_addr = 40'h8B_3333_0080; req_core = 4'd8;
      cfg_wr = 1'b1; cfg_mode = 3'd2; cfg_size = 6'd36;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R9 held err", int'(cfg_err), 1);
      for (int k = 0; k < 3; k++) begin
         chk("R11 hold valid", int'(rsp_valid), 1);
         chk("R11 hold ha", int'(rsp_ha), exp_ha(1, 36, 40'hA1_0000_1240));
         chk("R11 hold mc", int'(rsp_mc), exp_mc(1, 36, 40'hA1_0000_1240));
         chk("R11 hold core", int'(rsp_core), 4);
         @(negedge clk);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 second valid", int'(rsp_valid), 1);
      chk("R10 second ha", int'(rsp_ha), exp_ha(1, 36, 40'h8B_3333_0080));
      chk("R10 second mc", int'(rsp_mc), exp_mc(1, 36, 40'h8B_3333_0080));
      chk("R10 second core", int'(rsp_core), 8);
      @(negedge clk);
      chk("R10 drained", int'(rsp_valid), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule